// File: doc/BRIEF.md
# Quadrature to Step/Direction Converter

This block turns the two phase-shifted square waves of an incremental encoder into a step-and-direction pulse stream. Both phases are brought into the clock domain through a synchronizer chain and then sampled on every rising clock edge. Each time the sampled pair moves to a neighbouring Gray-code state, the block drives the direction output to the sense of travel and raises a step pulse for exactly one clock. A jump to the opposite Gray state, which means both phases changed between two samples, cannot be resolved. In that case the step is withheld and an error flag pulses for one clock instead.

Downstream logic such as a stepper driver, a pulse counter or a motion gate consumes the step and direction pair directly. The phases must not change more often than once every two clocks. After reset, the block primes its memory of the previous state from the live inputs. An encoder that is parked at any state therefore produces no step when reset is released.

Top module: `quad_step_conv`

## Requirements
- R1: While reset is asserted, step_o, dir_o and err_o are all 0.
- R2: A change on the phase inputs reaches the outputs on the third rising clock edge after it is applied. At the second edge step_o is still 0.
- R3: A move along the forward order of {A,B}, which is 00, 01, 11, 10 and back to 00, produces one step pulse with dir_o = 1 in the same cycle.
- R4: A move against that order produces one step pulse with dir_o = 0 in the same cycle. On a reversal, dir_o takes its new value in the cycle in which the step is high.
- R5: Every step pulse lasts exactly one clock period.
- R6: If A and B both change between two samples (00↔11 or 01↔10), no step is issued, dir_o keeps its value and err_o is 1 for exactly one clock.
- R7: dir_o changes only in a cycle in which step_o is 1.
- R8: While the inputs are steady, step_o and err_o stay 0.
- R9: When reset is released with the inputs at any value, no step or error is issued as a result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| quad_a_i | input | 1 | Encoder phase A, asynchronous |
| quad_b_i | input | 1 | Encoder phase B, asynchronous |
| step_o | output | 1 | One-clock pulse per legal state change |
| dir_o | output | 1 | Sense of travel: 1 forward, 0 reverse |
| err_o | output | 1 | One-clock pulse on a double-phase jump |

## Verification
On a reversal of travel, the step pulse and the change of direction fall in the same clock. The bench provokes this by moving forward and then stepping straight back. In the cycle where step_o is high, it expects dir_o to already hold the new sense, and it expects no edge on dir_o in any other cycle. A second collision happens at reset release, when the priming of the previous state meets an input parked at a non-zero state. The bench judges this by seeing no step and no error during the cycles after release.

// File: rtl/quad_step_pkg.sv
package quad_step_pkg;

  typedef enum logic [1:0] {
    MV_NONE = 2'd0,
    MV_FWD  = 2'd1,
    MV_REV  = 2'd2,
    MV_BAD  = 2'd3
  } move_e;

  // Position of an {A,B} pair along the forward cycle 00,01,11,10.
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/qs_rst_sync.sv
module qs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/qs_sync.sv
module qs_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/qs_decode.sv
module qs_decode
  import quad_step_pkg::*;
(
  input  logic [1:0] cur_i,
  input  logic [1:0] prev_i,
  output move_e      move_o
);
  logic [1:0] delta;

  always_comb begin
    delta = gray_pos(cur_i) - gray_pos(prev_i);
    unique case (delta)
      2'd1:    move_o = MV_FWD;
      2'd3:    move_o = MV_REV;
      2'd2:    move_o = MV_BAD;
      default: move_o = MV_NONE;
    endcase
  end
endmodule

// File: rtl/quad_step_conv.sv
module quad_step_conv
  import quad_step_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic quad_a_i,
  input  logic quad_b_i,
  output logic step_o,
  output logic dir_o,
  output logic err_o
);
  localparam int PRIME_CYC = SYNC_STAGES + 1;
  localparam int PW        = $clog2(PRIME_CYC + 1);

  logic          rst_n_int;
  logic [1:0]    cur_ab;
  logic [1:0]    prev_q, prev_d;
  logic [PW-1:0] prime_q, prime_d;
  logic          armed;
  move_e         move;
  logic          step_d, dir_d, err_d;

  qs_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_int)
  );

  qs_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_n_int),
    .d_i   ({quad_a_i, quad_b_i}),
    .q_o   (cur_ab)
  );

  qs_decode u_dec (
    .cur_i (cur_ab),
    .prev_i(prev_q),
    .move_o(move)
  );

  assign armed = (prime_q == PW'(PRIME_CYC));

  // Next-state logic
  always_comb begin
    prev_d  = cur_ab;
    prime_d = armed ? prime_q : prime_q + 1'b1;
    step_d  = 1'b0;
    err_d   = 1'b0;
    dir_d   = dir_o;
    if (armed) begin
      unique case (move)
        MV_FWD:  begin step_d = 1'b1; dir_d = 1'b1; end
        MV_REV:  begin step_d = 1'b1; dir_d = 1'b0; end
        MV_BAD:  err_d = 1'b1;
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      prev_q  <= '0;
      prime_q <= '0;
      step_o  <= 1'b0;
      dir_o   <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      prime_q <= prime_d;
      step_o  <= step_d;
      dir_o   <= dir_d;
      err_o   <= err_d;
    end
  end
endmodule

// File: rtl/quad_step_checker.sv
module quad_step_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic quad_a_i,
  input logic quad_b_i,
  input logic step_o,
  input logic dir_o,
  input logic err_o
);
  logic [3:0] cyc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cyc_q <= '0;
    else if (cyc_q != 4'hF)   cyc_q <= cyc_q + 1'b1;
  end

  // R1: outputs quiet while reset is held
  always_comb begin
    if (!rst_ni) a_r1_reset_quiet: assert (!step_o && !dir_o && !err_o);
  end

  // R2: a step traces back to an input change three samples earlier
  a_r2_step_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cyc_q >= 4'd6) |->
      ($past(quad_a_i,3) != $past(quad_a_i,4) || $past(quad_b_i,3) != $past(quad_b_i,4)));

  // R5: step lasts one clock
  a_r5_step_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_o |=> !step_o);

  // R6: error pulse is one clock and never coincides with a step
  a_r6_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  a_r6_err_no_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step_o && err_o));

  // R7: direction moves only together with a step
  a_r7_dir_with_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 4'd2 && dir_o != $past(dir_o)) |-> step_o);

  // R9: nothing is issued while the block primes after reset
  a_r9_prime_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q < 4'd6) |-> (!step_o && !err_o));
endmodule

bind quad_step_conv quad_step_checker u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .quad_a_i(quad_a_i),
  .quad_b_i(quad_b_i),
  .step_o  (step_o),
  .dir_o   (dir_o),
  .err_o   (err_o)
);

// File: tb/quad_step_conv_bench.sv
module quad_step_conv_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic qa, qb;
  logic step, dir, err;
  int   total = 0;
  int   bad   = 0;
  bit   done  = 1'b0;

  always #5 clk = ~clk;

  quad_step_conv u_quad_step_conv (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .quad_a_i(qa),
    .quad_b_i(qb),
    .step_o  (step),
    .dir_o   (dir),
    .err_o   (err)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // Apply {a,b}, check latency and the result cycle, then the cycle after.
  task automatic move(input string req, input logic [1:0] ab,
                      input logic exp_step, input logic exp_dir, input logic exp_err);
    @(negedge clk);
    {qa, qb} = ab;
    repeat (2) @(posedge clk);
    #1;
    check("R2", "step before third edge", step, 1'b0);
    @(posedge clk); #1;
    check(req, "step", step, exp_step);
    check(req, "dir",  dir,  exp_dir);
    check(req, "err",  err,  exp_err);
    @(posedge clk); #1;
    check("R5", "step after one cycle", step, 1'b0);
    check("R6", "err after one cycle",  err,  1'b0);
    check("R7", "dir held", dir, exp_dir);
    repeat (2) @(posedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    {qa, qb} = 2'b11;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "step in reset", step, 1'b0);
    check("R1", "dir in reset",  dir,  1'b0);
    check("R1", "err in reset",  err,  1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); #1;
      check("R9", "no step after release", step, 1'b0);
      check("R9", "no err after release",  err,  1'b0);
    end
  endtask

  task automatic t_forward;
    move("R3", 2'b10, 1'b1, 1'b1, 1'b0);
    move("R3", 2'b00, 1'b1, 1'b1, 1'b0);
    move("R3", 2'b01, 1'b1, 1'b1, 1'b0);
    move("R3", 2'b11, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_reverse;
    move("R4", 2'b01, 1'b1, 1'b0, 1'b0);
    move("R4", 2'b00, 1'b1, 1'b0, 1'b0);
    move("R4", 2'b10, 1'b1, 1'b0, 1'b0);
    move("R4", 2'b11, 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_reversal;
    move("R3", 2'b10, 1'b1, 1'b1, 1'b0);
    move("R4", 2'b11, 1'b1, 1'b0, 1'b0);
    move("R3", 2'b10, 1'b1, 1'b1, 1'b0);
  endtask

  task automatic t_illegal;
    // state 10 -> 01 : both phases flip, dir stays 1
    move("R6", 2'b01, 1'b0, 1'b1, 1'b1);
    // 01 -> 10 back again, still illegal
    move("R6", 2'b10, 1'b0, 1'b1, 1'b1);
  endtask

  task automatic t_hold;
    for (int i = 0; i < 10; i++) begin
      @(posedge clk); #1;
      check("R8", "step while steady", step, 1'b0);
      check("R8", "err while steady",  err,  1'b0);
      check("R7", "dir while steady",  dir,  1'b1);
    end
  endtask

  initial begin
    t_reset();
    t_forward();
    t_reverse();
    t_reversal();
    t_illegal();
    t_hold();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule